// File: doc/BRIEF.md
# Cache lookup event counter

This block counts cache lookup outcomes selected by a programmable event mask. In each cycle it receives at most one lookup report. A report names the operation (load, read-for-ownership or writeback), the cache level (second or third) and the outcome (a miss, or a hit with line state Shared, Exclusive or Modified). Loads and read-for-ownership requests are both classified as reads. Writebacks only matter when they miss the second level.

Two configuration registers are written through one write port. Register 0 holds the 16-bit event mask. Register 1 holds a 3-bit counter-select field, which must equal 7 for counting to take place. The wide counter can be read at any time and is cleared by a synchronous input.

Top module: `cache_evt_counter`

## Requirements
- R1: Reset sets the counter, the stored mask and the stored select field to zero.
- R2: A write to address 0 stores mask bit n from write-data bit 9+n (bits 24:9). A write to address 1 stores the select field from write-data bits 15:13. Both are visible on the readback outputs one cycle after the write.
- R3: When mask bit 0, 1 or 2 is set, a second-level read hit in state Shared (result 1), Exclusive (result 2) or Modified (result 3) respectively adds one to the counter.
- R4: When mask bit 3, 4 or 5 is set, a third-level read hit in state Shared, Exclusive or Modified respectively adds one to the counter.
- R5: When mask bit 8 is set, a second-level read miss (result 0) adds one. When mask bit 9 is set, a third-level read miss adds one.
- R6: Operation code 0 (load) and code 1 (read-for-ownership) count the same way for every read mask bit. Operation code 3 never counts.
- R7: When mask bit 10 is set, a writeback (operation code 2) that misses the second level (level 0, result 0) adds one. A writeback never counts on a hit or at the third level.
- R8: Mask bits 6, 7 and 11 to 15 are stored and read back, but never cause a count.
- R9: Counting takes place only while the stored select field equals 7.
- R10: A matching lookup adds exactly one, and the counter wraps to zero on overflow.
- R11: Asserting the clear input sets the counter to zero at the next edge. Clear has priority over a matching lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = event mask register, 1 = counter-select register |
| cfg_wdata | input | 32 | Configuration write data |
| lk_valid | input | 1 | A lookup report is present this cycle |
| lk_op | input | 2 | 0 load, 1 read-for-ownership, 2 writeback, 3 other |
| lk_level | input | 1 | 0 second level, 1 third level |
| lk_result | input | 2 | 0 miss, 1 Shared hit, 2 Exclusive hit, 3 Modified hit |
| cnt_clr | input | 1 | Synchronous counter clear |
| cnt_value | output | CNT_W (40) | Event counter |
| mask_q | output | 16 | Stored event mask |
| sel_q | output | 3 | Stored counter-select field |

## Verification
The assertions assume that reports, writes and clears are sampled on the clock edge. They also assume that the counter changes only through a matching lookup or a clear. The bench drives every input on the falling edge, so it never changes signals near a sampling edge. It uses only the defined operation, level and result codes, plus operation code 3 as the one deliberate out-of-class value. A second, narrow-counter instance shares the same stimulus so that wrap-around is reached within the run.

// File: rtl/cache_evt_counter.sv
module cache_evt_counter #(
  parameter int CNT_W    = 40,
  parameter int MASK_W   = 16,
  parameter int SEL_W    = 3,
  parameter int MASK_LSB = 9,
  parameter int SEL_LSB  = 13,
  parameter int SEL_ON   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             lk_valid,
  input  logic [1:0]       lk_op,
  input  logic             lk_level,
  input  logic [1:0]       lk_result,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] cnt_value,
  output logic [MASK_W-1:0] mask_q,
  output logic [SEL_W-1:0] sel_q
);
  localparam int MASK_MSB = MASK_LSB + MASK_W - 1;
  localparam int SEL_MSB  = SEL_LSB + SEL_W - 1;

  logic       is_read, is_wb, is_hit, hit_match, miss_match, wb_match, inc;
  logic [2:0] state_1h, hit_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr) sel_q  <= cfg_wdata[SEL_MSB:SEL_LSB];
      else          mask_q <= cfg_wdata[MASK_MSB:MASK_LSB];
    end
  end

  assign is_read  = (lk_op == 2'd0) || (lk_op == 2'd1);
  assign is_wb    = (lk_op == 2'd2);
  assign is_hit   = (lk_result != 2'd0);
  assign state_1h = {lk_result == 2'd3, lk_result == 2'd2, lk_result == 2'd1};
  assign hit_bits = lk_level ? mask_q[5:3] : mask_q[2:0];

  assign hit_match  = is_read && is_hit && |(hit_bits & state_1h);
  assign miss_match = is_read && !is_hit && (lk_level ? mask_q[9] : mask_q[8]);
  assign wb_match   = is_wb && !is_hit && !lk_level && mask_q[10];

  assign inc = lk_valid && (sel_q == SEL_W'(SEL_ON)) &&
               (hit_match || miss_match || wb_match);

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr) cnt_value <= '0;
    else if (inc)          cnt_value <= cnt_value + 1'b1;
  end
endmodule

module cache_evt_counter_chk #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [1:0]       lk_op,
  input logic             lk_level,
  input logic [1:0]       lk_result,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_value,
  input logic [2:0]       sel_q
);
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_value == '0));

  a_r9_gated_by_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && sel_q != 3'd7) |=> $stable(cnt_value));

  a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_value == $past(cnt_value) || cnt_value == $past(cnt_value) + 1'b1));

  a_r6_other_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && lk_valid && lk_op == 2'd3) |=> $stable(cnt_value));

  a_r7_wb_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && lk_valid && lk_op == 2'd2 && (lk_result != 2'd0 || lk_level)) |=> $stable(cnt_value));

  a_r10_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !lk_valid) |=> $stable(cnt_value));
endmodule

bind cache_evt_counter cache_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_op(lk_op),
  .lk_level(lk_level), .lk_result(lk_result), .cnt_clr(cnt_clr),
  .cnt_value(cnt_value), .sel_q(sel_q)
);

// File: tb/cache_evt_counter_tb.sv
`timescale 1ns/1ps
module cache_evt_counter_tb;
  logic        clk = 0, rst_n = 0, cfg_we = 0, cfg_addr = 0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 0, lk_level = 0, cnt_clr = 0;
  logic [1:0]  lk_op = '0, lk_result = '0;
  logic [39:0] cnt_value;
  logic [3:0]  cnt_small;
  logic [15:0] mask_q, mask_s;
  logic [2:0]  sel_q, sel_s;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [39:0] exp_cnt = '0;
  logic [15:0] sh_mask = '0;
  logic [2:0]  sh_sel = '0;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cache_evt_counter u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_op(lk_op), .lk_level(lk_level),
    .lk_result(lk_result), .cnt_clr(cnt_clr), .cnt_value(cnt_value), .mask_q(mask_q), .sel_q(sel_q));

  cache_evt_counter #(.CNT_W(4)) u_small (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_op(lk_op),
    .lk_level(lk_level), .lk_result(lk_result), .cnt_clr(cnt_clr), .cnt_value(cnt_small),
    .mask_q(mask_s), .sel_q(sel_s));

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model(input logic [15:0] m, input logic [1:0] op, input logic lvl, input logic [1:0] res);
    if (op <= 2'd1) begin
      if (res == 2'd0) return lvl ? m[9] : m[8];
      return m[(lvl ? 3 : 0) + int'(res) - 1];
    end
    if (op == 2'd2) return (!lvl && res == 2'd0 && m[10]);
    return 0;
  endfunction

  // monitor: pops expected counts and compares one half cycle after the update
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      automatic logic [39:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(cnt_value == e, t, cnt_value, e);
      check(cnt_small == e[3:0], "R10 narrow wrap", {36'd0, cnt_small}, {36'd0, e[3:0]});
    end
  end

  task automatic push(input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp_cnt);
    tag_q.push_back(tag);
  endtask

  task automatic write_cfg(input logic a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a) sh_sel = d[15:13]; else sh_mask = d[24:9];
    push("R2 write leaves count");
    cfg_we = 0;
    check(mask_q == sh_mask && mask_s == sh_mask, "R2 mask readback", {24'd0, mask_q}, {24'd0, sh_mask});
    check(sel_q == sh_sel && sel_s == sh_sel, "R2 select readback", {37'd0, sel_q}, {37'd0, sh_sel});
  endtask

  task automatic lookup(input logic [1:0] op, input logic lvl, input logic [1:0] res, input bit clr, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_op = op; lk_level = lvl; lk_result = res; cnt_clr = clr;
    if (clr) exp_cnt = '0;
    else if (sh_sel == 3'd7 && model(sh_mask, op, lvl, res)) exp_cnt = exp_cnt + 1;
    push(tag);
    lk_valid = 0; cnt_clr = 0;
  endtask

  task automatic sweep(input string tag);
    for (int o = 0; o < 4; o++)
      for (int l = 0; l < 2; l++)
        for (int r = 0; r < 4; r++)
          lookup(2'(o), 1'(l), 2'(r), 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cnt_value == 0 && mask_q == 0 && sel_q == 0, "R1 reset state",
          cnt_value ^ {24'd0, mask_q} ^ {37'd0, sel_q}, 0);
    rst_n = 1;
    write_cfg(0, 32'h0000_073F << 9 >> 9 << 9);
    lookup(0, 0, 1, 0, "R9 select not 7 blocks count");
    write_cfg(1, 32'd6 << 13);
    sweep("R9 select 6 blocks count");
    write_cfg(1, 32'd7 << 13);
    sweep("R3 R4 R5 R6 R7 all defined bits");
    for (int b = 0; b < 11; b++) begin
      write_cfg(0, 32'(1 << b) << 9);
      sweep($sformatf("R3 R4 R5 R7 single mask bit %0d", b));
    end
    write_cfg(0, 32'h0000_F8C0 << 9);
    sweep("R8 reserved bits never count");
    write_cfg(0, 32'h0000_0007 << 9);
    for (int i = 0; i < 20; i++) lookup(2'(i % 2), 0, 2'(1 + i % 3), 0, "R10 increment and wrap");
    lookup(0, 0, 1, 1, "R11 clear wins over match");
    lookup(1, 0, 2, 0, "R6 ownership read after clear");
    lookup(0, 0, 3, 1, "R11 clear");
    lookup(2, 0, 0, 0, "R7 writeback not selected");
    @(negedge clk);
    check(cnt_value == exp_cnt, "R11 final", cnt_value, exp_cnt);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule